// File: doc/BRIEF.md
# Idle and Zero-Power State Controller

This block decides how much of a modem controller is powered at any moment. It watches the host control lines, the serial transmit line, the hardware reset pin, a set of auxiliary inputs and a ring-detect input. All of these pass through two-flop synchronisers before any edge is detected. After a programmable number of millisecond ticks without activity, it drops the core supply. The first sign of activity brings the core supply back. The host never has to take part in either step.

A latched zero-power state removes all supplies. Two things can request it: an explicit command strobe from the controller, or a change on the terminal-ready line when the terminal-ready response option selects power-off. Only a reset pin pulse held high long enough releases this state. Once such a pulse has qualified, the block waits for the pin to fall. It then holds off command acceptance for a settle time. The same settle time follows a chip reset.

The outputs are a core power enable, an I/O power enable and a command-ready flag. The analog switches that act on these enables are outside the block.

Top module: `pwr_ctl`

## Requirements
- R1: While and right after the asynchronous chip reset, `core_pwr_en`=1, `io_pwr_en`=1 and `cmd_ready`=0.
- R2: `cmd_ready` rises only after SETTLE_TICKS ticks following a chip reset or the fall of a qualified reset pin pulse. Zero-power requests during that window are ignored.
- R3: With `idle_en`=1 and the block ready, `idle_timeout` consecutive ticks without activity clear `core_pwr_en`. `io_pwr_en` and `cmd_ready` stay 1.
- R4: With `idle_en`=0, inactivity never clears `core_pwr_en`.
- R5: Activity is any of the following, seen after two synchroniser flops: a change on `dtr_n`, `txd`, `rst_pin` or any `aux_in` bit, or `ring_det` high. Activity wakes the idle state within a few cycles and restarts the inactivity count.
- R6: A one-cycle `zp_req` while ready drives all three outputs to 0.
- R7: A change on `dtr_n` enters zero power only when `dtr_action` is 2'b11. Any other code leaves the supplies unchanged.
- R8: Zero power is latched. Activity and further requests do not leave it.
- R9: `rst_pin` held high for RST_MIN_TICKS ticks moves the block from any state to a reset-hold state with `core_pwr_en`=1, `io_pwr_en`=1 and `cmd_ready`=0. A shorter pulse is ignored.
- R10: From reset-hold, the fall of `rst_pin` starts the settle window of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| idle_en | input | 1 | Idle enable, bit 1 of the power option register |
| idle_timeout | input | TO_W | Inactivity limit in ticks |
| dtr_action | input | 2 | Terminal-ready response code; 2'b11 selects power-off |
| zp_req | input | 1 | Synchronous zero-power command strobe |
| dtr_n | input | 1 | Terminal-ready line, asynchronous |
| txd | input | 1 | Serial transmit line, asynchronous |
| rst_pin | input | 1 | Active-high hardware reset pin, asynchronous |
| ring_det | input | 1 | Ring detected, asynchronous |
| aux_in | input | N_AUX | Other monitored inputs, asynchronous |
| core_pwr_en | output | 1 | Core supply enable |
| io_pwr_en | output | 1 | I/O supply enable |
| cmd_ready | output | 1 | Commands may be accepted |

## Verification
The bench builds the block with CLKS_PER_TICK=4, RST_MIN_TICKS=6, SETTLE_TICKS=10 and an `idle_timeout` of 8. At these values a tick lasts four cycles and each window takes only tens of cycles. This brings the idle entry, the wake paths, the short and long reset pulses and the settle hold-off within a short run. The sampling points leave a margin of several cycles on both sides of each window edge, so that the synchroniser latency does not blur the result.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [2:0] {
    PS_SETTLE = 3'd0,
    PS_ACTIVE = 3'd1,
    PS_IDLE   = 3'd2,
    PS_ZERO   = 3'd3,
    PS_HOLD   = 3'd4
  } pwr_state_t;

  localparam logic [1:0] DTR_ACT_POWER_OFF = 2'b11;
endpackage

// File: rtl/pwr_tick_gen.sv
module pwr_tick_gen #(
  parameter int CLKS_PER_TICK = 50000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_TICK - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = wrap;
endmodule

// File: rtl/pwr_act_detect.sv
module pwr_act_detect #(
  parameter int N_AUX = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dtr_n,
  input  logic             txd,
  input  logic             rst_pin,
  input  logic             ring_det,
  input  logic [N_AUX-1:0] aux_in,
  output logic             act,
  output logic             dtr_edge,
  output logic             rst_lvl
);
  localparam int NW = N_AUX + 4;
  localparam int IDX_DTR  = 0;
  localparam int IDX_RING = 3;

  logic [NW-1:0] raw, s1_q, s2_q, prev_q, chg;

  assign raw = {aux_in, ring_det, rst_pin, txd, dtr_n};

  // two-stage synchroniser followed by one history stage per line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= raw;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NW; g++) begin : g_edge
      if (g == IDX_RING) begin : g_lvl
        assign chg[g] = s2_q[g];
      end else begin : g_tgl
        assign chg[g] = s2_q[g] ^ prev_q[g];
      end
    end
  endgenerate

  assign act      = |chg;
  assign dtr_edge = chg[IDX_DTR];
  assign rst_lvl  = s2_q[2];
endmodule

// File: rtl/pwr_rst_qual.sv
module pwr_rst_qual #(
  parameter int RST_MIN_TICKS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rst_lvl,
  output logic rst_qual
);
  localparam int QW = $clog2(RST_MIN_TICKS + 1);
  localparam logic [QW-1:0] QMAX = QW'(RST_MIN_TICKS);

  logic [QW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!rst_lvl)                 cnt_d = '0;
    else if (tick && cnt_q != QMAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign rst_qual = (cnt_q == QMAX);
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_pkg::*;
#(
  parameter int SETTLE_TICKS = 500,
  parameter int TO_W         = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            act,
  input  logic            dtr_edge,
  input  logic            zp_req,
  input  logic            rst_lvl,
  input  logic            rst_qual,
  input  logic            idle_en,
  input  logic [1:0]      dtr_action,
  input  logic [TO_W-1:0] idle_timeout,
  output logic            core_pwr_en,
  output logic            io_pwr_en,
  output logic            cmd_ready
);
  localparam int SW = $clog2(SETTLE_TICKS + 1);
  localparam logic [SW-1:0] SLOAD = SW'(SETTLE_TICKS);

  pwr_state_t      st_q, st_d;
  logic [SW-1:0]   settle_q, settle_d;
  logic [TO_W-1:0] idle_q, idle_d;
  logic [TO_W:0]   idle_inc;
  logic            zero_go;

  assign zero_go  = zp_req | (dtr_edge & (dtr_action == DTR_ACT_POWER_OFF));
  assign idle_inc = {1'b0, idle_q} + 1'b1;

  always_comb begin
    st_d     = st_q;
    settle_d = settle_q;
    idle_d   = idle_q;
    if (rst_qual) begin
      st_d = PS_HOLD;
    end else begin
      case (st_q)
        PS_HOLD: begin
          if (!rst_lvl) begin
            st_d     = PS_SETTLE;
            settle_d = SLOAD;
          end
        end
        PS_SETTLE: begin
          if (tick) begin
            if (settle_q <= 1) begin
              st_d   = PS_ACTIVE;
              idle_d = '0;
            end else begin
              settle_d = settle_q - 1'b1;
            end
          end
        end
        PS_ACTIVE: begin
          if (zero_go) begin
            st_d = PS_ZERO;
          end else if (act) begin
            idle_d = '0;
          end else if (tick) begin
            if (idle_en && idle_inc >= {1'b0, idle_timeout}) st_d = PS_IDLE;
            else if (!idle_inc[TO_W])                        idle_d = idle_inc[TO_W-1:0];
          end
        end
        PS_IDLE: begin
          if (zero_go) begin
            st_d = PS_ZERO;
          end else if (act) begin
            st_d   = PS_ACTIVE;
            idle_d = '0;
          end
        end
        PS_ZERO: st_d = PS_ZERO;
        default: st_d = PS_SETTLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= PS_SETTLE;
      settle_q <= SLOAD;
      idle_q   <= '0;
    end else begin
      st_q     <= st_d;
      settle_q <= settle_d;
      idle_q   <= idle_d;
    end
  end

  assign core_pwr_en = (st_q != PS_IDLE) && (st_q != PS_ZERO);
  assign io_pwr_en   = (st_q != PS_ZERO);
  assign cmd_ready   = (st_q == PS_ACTIVE) || (st_q == PS_IDLE);
endmodule

// File: rtl/pwr_ctl.sv
module pwr_ctl #(
  parameter int CLKS_PER_TICK = 50000,
  parameter int RST_MIN_TICKS = 50,
  parameter int SETTLE_TICKS  = 500,
  parameter int TO_W          = 16,
  parameter int N_AUX         = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_en,
  input  logic [TO_W-1:0]  idle_timeout,
  input  logic [1:0]       dtr_action,
  input  logic             zp_req,
  input  logic             dtr_n,
  input  logic             txd,
  input  logic             rst_pin,
  input  logic             ring_det,
  input  logic [N_AUX-1:0] aux_in,
  output logic             core_pwr_en,
  output logic             io_pwr_en,
  output logic             cmd_ready
);
  logic tick, act_any, dtr_edge, rst_lvl, rst_qual;

  pwr_tick_gen #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  pwr_act_detect #(.N_AUX(N_AUX)) u_act (
    .clk(clk), .rst_n(rst_n), .dtr_n(dtr_n), .txd(txd), .rst_pin(rst_pin),
    .ring_det(ring_det), .aux_in(aux_in), .act(act_any),
    .dtr_edge(dtr_edge), .rst_lvl(rst_lvl)
  );

  pwr_rst_qual #(.RST_MIN_TICKS(RST_MIN_TICKS)) u_qual (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rst_lvl(rst_lvl), .rst_qual(rst_qual)
  );

  pwr_fsm #(.SETTLE_TICKS(SETTLE_TICKS), .TO_W(TO_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .act(act_any), .dtr_edge(dtr_edge),
    .zp_req(zp_req), .rst_lvl(rst_lvl), .rst_qual(rst_qual), .idle_en(idle_en),
    .dtr_action(dtr_action), .idle_timeout(idle_timeout),
    .core_pwr_en(core_pwr_en), .io_pwr_en(io_pwr_en), .cmd_ready(cmd_ready)
  );
endmodule

// File: rtl/pwr_ctl_chk.sv
module pwr_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic idle_en,
  input logic zp_req,
  input logic act_any,
  input logic rst_qual,
  input logic core_pwr_en,
  input logic io_pwr_en,
  input logic cmd_ready
);
  AST_IDLE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(core_pwr_en) && io_pwr_en) |-> $past(idle_en)); // R4

  AST_IDLE_FROM_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(core_pwr_en) && io_pwr_en) |-> ($past(cmd_ready) && cmd_ready)); // R3

  AST_WAKE_ON_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_pwr_en && io_pwr_en && act_any) |=> (core_pwr_en || !io_pwr_en)); // R5

  AST_ZERO_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_pwr_en && !rst_qual) |=> !io_pwr_en); // R8

  AST_READY_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_ready) |-> (!io_pwr_en || $past(rst_qual))); // R9

  AST_NO_ZERO_IN_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && io_pwr_en && zp_req) |=> io_pwr_en); // R2
endmodule

bind pwr_ctl pwr_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .idle_en(idle_en), .zp_req(zp_req),
  .act_any(act_any), .rst_qual(rst_qual), .core_pwr_en(core_pwr_en),
  .io_pwr_en(io_pwr_en), .cmd_ready(cmd_ready)
);

// File: tb/pwr_ctl_test.sv
module pwr_ctl_test;
  localparam int TO_W  = 16;
  localparam int N_AUX = 4;

  logic clk, rst_n, idle_en, zp_req, dtr_n, txd, rst_pin, ring_det;
  logic [TO_W-1:0]  idle_timeout;
  logic [1:0]       dtr_action;
  logic [N_AUX-1:0] aux_in;
  logic core_pwr_en, io_pwr_en, cmd_ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  pwr_ctl #(.CLKS_PER_TICK(4), .RST_MIN_TICKS(6), .SETTLE_TICKS(10),
            .TO_W(TO_W), .N_AUX(N_AUX)) uut (
    .clk(clk), .rst_n(rst_n), .idle_en(idle_en), .idle_timeout(idle_timeout),
    .dtr_action(dtr_action), .zp_req(zp_req), .dtr_n(dtr_n), .txd(txd),
    .rst_pin(rst_pin), .ring_det(ring_det), .aux_in(aux_in),
    .core_pwr_en(core_pwr_en), .io_pwr_en(io_pwr_en), .cmd_ready(cmd_ready)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // action codes: 0 none, 1 txd toggle, 2 dtr toggle, 3 zp pulse, 4 rst high,
  // 5 rst low, 6 ring high, 7 ring low, 8 aux toggle
  // row = {action[3:0], wait[7:0], exp core, exp io, exp ready, req[3:0]}
  localparam int NV = 16;
  localparam logic [18:0] VEC [NV] = '{
    {4'd1, 8'd16, 3'b111, 4'd5},  // R5 activity keeps awake
    {4'd0, 8'd40, 3'b011, 4'd3},  // R3 idle after timeout
    {4'd1, 8'd8,  3'b111, 4'd5},  // R5 txd wakes
    {4'd0, 8'd40, 3'b011, 4'd3},  // R3
    {4'd6, 8'd8,  3'b111, 4'd5},  // R5 ring wakes
    {4'd7, 8'd40, 3'b011, 4'd3},  // R3
    {4'd8, 8'd8,  3'b111, 4'd5},  // R5 aux wakes
    {4'd3, 8'd8,  3'b000, 4'd6},  // R6 command power-off
    {4'd1, 8'd8,  3'b000, 4'd8},  // R8 activity ignored
    {4'd4, 8'd12, 3'b000, 4'd9},  // R9 short pulse
    {4'd5, 8'd12, 3'b000, 4'd9},  // R9 short pulse ignored
    {4'd4, 8'd40, 3'b110, 4'd9},  // R9 qualified hold
    {4'd5, 8'd20, 3'b110, 4'd10}, // R10 settle after release
    {4'd0, 8'd40, 3'b111, 4'd10}, // R10 ready after settle
    {4'd2, 8'd8,  3'b000, 4'd7},  // R7 dtr toggle powers off
    {4'd4, 8'd40, 3'b110, 4'd9}   // R9 hold from zero
  };

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {core_pwr_en, io_pwr_en, cmd_ready};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s core/io/ready actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_action(input logic [3:0] a);
    case (a)
      4'd1: txd = ~txd;
      4'd2: dtr_n = ~dtr_n;
      4'd3: begin zp_req = 1'b1; @(negedge clk); zp_req = 1'b0; end
      4'd4: rst_pin = 1'b1;
      4'd5: rst_pin = 1'b0;
      4'd6: ring_det = 1'b1;
      4'd7: ring_det = 1'b0;
      4'd8: aux_in[2] = ~aux_in[2];
      default: ;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle_en = 1; idle_timeout = 16'd8; dtr_action = 2'b11;
    zp_req = 0; dtr_n = 1; txd = 1; rst_pin = 0; ring_det = 0; aux_in = '0;
    wait_cyc(3);
    check("R1", 3'b110);
    rst_n = 1;
    wait_cyc(20);
    check("R2", 3'b110);
    wait_cyc(40);
    check("R2", 3'b111);

    for (int i = 0; i < NV; i++) begin
      do_action(VEC[i][18:15]);
      wait_cyc(int'(VEC[i][14:7]));
      check($sformatf("R%0d row %0d", VEC[i][3:0], i), VEC[i][6:4]);
    end
    do_action(4'd5);
    wait_cyc(60);
    check("R10", 3'b111);

    // R7: other response codes leave supplies on
    dtr_action = 2'b01;
    do_action(4'd2);
    wait_cyc(8);
    check("R7", 3'b111);

    // R4: idle disabled
    idle_en = 0;
    wait_cyc(80);
    check("R4", 3'b111);
    idle_en = 1;

    // R2: power-off request inside settle window ignored
    do_action(4'd4);
    wait_cyc(40);
    do_action(4'd5);
    wait_cyc(8);
    check("R2", 3'b110);
    do_action(4'd3);
    wait_cyc(60);
    check("R2", 3'b111);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule